// File: doc/BRIEF.md
# Cell balancing channel controller

This block drives the discharge switches of a stack of battery cells, one switch per cell. Software sets it up through a small write port: a master enable, a global run-time budget, a start delay, a channel enable mask, a run-time budget per channel, a global and a per-channel low-voltage limit, a duty setting per channel and a pair of temperature limits. A prescaled time strobe from outside paces every timer and the duty-cycle counter.

Each channel's switch is on only when no stop condition applies. The global conditions are: master enable off, global budget used up, any cell at or below the global low-voltage limit, the over-temperature lock-out, and the start delay still running. The per-channel conditions are: own mask bit clear, own cell at or below its limit, and own budget used up. A 3-bit reason code per channel reports the highest-priority condition that holds. Low-voltage stops stay latched until software writes the enable register again. The over-temperature stop clears by itself once the temperature falls to the low limit.

Top module: `cell_bal_ctrl`

## Requirements
- R1: A write with select 0 loads the master enable from data bit 0, and a write with select 1 loads the global budget. With the enable at 0 every channel reports code 1 and its switch is off. With the enable at 1 and the global budget at 0, every channel reports code 3.
- R2: The global budget counts down by one on each time strobe while the enable is 1 and the start delay is 0. When it reaches 0, every channel stops with code 3.
- R3: A write with select 4 loads the budget of the channel given by the channel index. That budget counts down on each strobe while the channel reports code 0. When it reaches 0, only that channel stops, with code 7.
- R4: A write with select 2 loads the start delay. While the delay is non-zero, channels report code 5. The delay counts down on each strobe while the enable is 1, and a value of 0 lets balancing start at once.
- R5: A write with select 6 sets the global low-voltage limit. On a voltage update strobe with the enable at 1, if any cell word is at or below that limit, every channel stops with code 2.
- R6: A write with select 5 sets the indexed channel's low-voltage limit. On an update with the enable at 1, a cell at or below its own limit stops only that channel, with code 6.
- R7: Selects 8 and 9 set the high and low temperature limits. A temperature at or above the high limit stops all channels with code 4. The stop holds until the temperature is at or below the low limit.
- R8: A write with select 3 loads the channel mask. A channel whose mask bit is 0 reports code 1 and stays off.
- R9: A duty counter of PWMW bits advances on each strobe and wraps. A channel reporting code 0 drives its switch while the counter is at most its duty setting (select 7, indexed). Over one full counter period, duty d therefore gives d+1 on-strobes.
- R10: Global and per-channel low-voltage stops stay latched after the cells recover. Any write to select 0 clears them.
- R11: Timers saturate at zero under further strobes. Writing a timer reloads it at once.
- R12: The reason code for channel i is in bits 3i+2:3i. The priority from highest to lowest is: disabled/masked (1), global low voltage (2), global budget (3), temperature (4), start delay (5), channel low voltage (6), channel budget (7). Code 0 means the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled time strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 4 | Configuration register select |
| cfg_ch_i | input | CHW | Channel index for per-channel registers |
| cfg_data_i | input | DW | Write data |
| cell_v_i | input | NCH*VW | Cell voltage words, channel i at bits i*VW |
| cell_upd_i | input | 1 | Voltage update strobe |
| temp_i | input | TEMPW | Temperature word, larger is hotter |
| bal_o | output | NCH | Balancing switch enables |
| reason_o | output | 3*NCH | Per-channel reason codes |

## Verification
All state here is visible at the ports within one clock. A timer off by one moves a reason-code transition by exactly one strobe. A latch that clears wrongly turns a stopped channel's code back to 0 on the next update. A temperature lock-out with the wrong hysteresis changes the codes at the band edges. A broken duty counter or compare changes how many on-strobes a channel gets in a full counter period, so sweeping every duty value on every channel shows the fault within one period.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic [2:0] {
    RS_ON  = 3'd0,
    RS_OFF = 3'd1,
    RS_GUV = 3'd2,
    RS_GTO = 3'd3,
    RS_HOT = 3'd4,
    RS_PRE = 3'd5,
    RS_CUV = 3'd6,
    RS_CTO = 3'd7
  } reason_e;

  typedef enum logic [3:0] {
    SEL_EN   = 4'd0,
    SEL_GTO  = 4'd1,
    SEL_PRE  = 4'd2,
    SEL_MASK = 4'd3,
    SEL_CTMR = 4'd4,
    SEL_CUV  = 4'd5,
    SEL_GUV  = 4'd6,
    SEL_DUTY = 4'd7,
    SEL_THI  = 4'd8,
    SEL_TLO  = 4'd9
  } cfg_sel_e;
endpackage

// File: rtl/cb_down_timer.sv
module cb_down_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (load_i)            cnt_o <= load_val_i;
    else if (dec_i && !zero_o)  cnt_o <= cnt_o - 1'b1;
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/cb_temp_lock.sv
module cb_temp_lock #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] temp_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic         hot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hot_o <= 1'b0;
    else if (temp_i >= hi_i) hot_o <= 1'b1;
    else if (temp_i <= lo_i) hot_o <= 1'b0;
  end
endmodule

// File: rtl/cb_chan.sv
module cb_chan
  import cb_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TW   = 16,
  parameter int VW   = 16,
  parameter int PWMW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            arm_i,
  input  logic            clr_i,
  input  logic            ld_tmr_i,
  input  logic            ld_thr_i,
  input  logic            ld_duty_i,
  input  logic [DW-1:0]   data_i,
  input  logic [VW-1:0]   v_i,
  input  logic            v_upd_i,
  input  logic            ch_en_i,
  input  reason_e         gate_i,
  input  logic [PWMW-1:0] pwm_cnt_i,
  output logic            bal_o,
  output reason_e         code_o
);
  logic [TW-1:0]   tmr_cnt;
  logic            tmr_zero;
  logic [VW-1:0]   thr_q;
  logic [PWMW-1:0] duty_q;
  logic            uv_q;

  cb_down_timer #(.W(TW)) i_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_tmr_i),
    .load_val_i (data_i[TW-1:0]),
    .dec_i      (tick_i && (code_o == RS_ON)),
    .cnt_o      (tmr_cnt),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      duty_q <= '1;
      uv_q   <= 1'b0;
    end else begin
      if (ld_thr_i)  thr_q  <= data_i[VW-1:0];
      if (ld_duty_i) duty_q <= data_i[PWMW-1:0];
      // clear by enable write wins over a same-cycle detection
      if (clr_i)                                 uv_q <= 1'b0;
      else if (arm_i && v_upd_i && v_i <= thr_q) uv_q <= 1'b1;
    end
  end

  always_comb begin
    if (!ch_en_i)            code_o = RS_OFF;
    else if (gate_i != RS_ON) code_o = gate_i;
    else if (uv_q)           code_o = RS_CUV;
    else if (tmr_zero)       code_o = RS_CTO;
    else                     code_o = RS_ON;
  end

  assign bal_o = (code_o == RS_ON) && (pwm_cnt_i <= duty_q);
endmodule

// File: rtl/cell_bal_ctrl.sv
module cell_bal_ctrl
  import cb_pkg::*;
#(
  parameter int NCH   = 14,
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int VW    = 16,
  parameter int TEMPW = 12,
  parameter int PWMW  = 3,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_sel_i,
  input  logic [CHW-1:0]   cfg_ch_i,
  input  logic [DW-1:0]    cfg_data_i,
  input  logic [NCH*VW-1:0] cell_v_i,
  input  logic             cell_upd_i,
  input  logic [TEMPW-1:0] temp_i,
  output logic [NCH-1:0]   bal_o,
  output logic [3*NCH-1:0] reason_o
);
  cfg_sel_e         sel;
  logic             wr_en, ld_gto, ld_pre;
  logic             en_q, glob_uv_q, hot;
  logic [NCH-1:0]   mask_q;
  logic [VW-1:0]    guv_thr_q;
  logic [TEMPW-1:0] t_hi_q, t_lo_q;
  logic [PWMW-1:0]  pwm_cnt_q;
  logic [TW-1:0]    gto_cnt, pre_cnt;
  logic             gto_zero, pre_zero, any_low;
  reason_e          gate;

  assign sel    = cfg_sel_e'(cfg_sel_i);
  assign wr_en  = cfg_we_i && (sel == SEL_EN);
  assign ld_gto = cfg_we_i && (sel == SEL_GTO);
  assign ld_pre = cfg_we_i && (sel == SEL_PRE);

  always_comb begin
    any_low = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (cell_v_i[i*VW +: VW] <= guv_thr_q) any_low = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      glob_uv_q <= 1'b0;
      mask_q    <= '0;
      guv_thr_q <= '0;
      t_hi_q    <= '1;
      t_lo_q    <= '0;
      pwm_cnt_q <= '0;
    end else begin
      if (wr_en) en_q <= cfg_data_i[0];
      if (cfg_we_i && sel == SEL_MASK) mask_q    <= cfg_data_i[NCH-1:0];
      if (cfg_we_i && sel == SEL_GUV)  guv_thr_q <= cfg_data_i[VW-1:0];
      if (cfg_we_i && sel == SEL_THI)  t_hi_q    <= cfg_data_i[TEMPW-1:0];
      if (cfg_we_i && sel == SEL_TLO)  t_lo_q    <= cfg_data_i[TEMPW-1:0];
      if (wr_en)                               glob_uv_q <= 1'b0;
      else if (en_q && cell_upd_i && any_low)  glob_uv_q <= 1'b1;
      if (tick_i) pwm_cnt_q <= pwm_cnt_q + 1'b1;
    end
  end

  cb_down_timer #(.W(TW)) i_gto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_gto),
    .load_val_i (cfg_data_i[TW-1:0]),
    .dec_i      (tick_i && en_q && pre_zero),
    .cnt_o      (gto_cnt),
    .zero_o     (gto_zero)
  );

  cb_down_timer #(.W(TW)) i_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_pre),
    .load_val_i (cfg_data_i[TW-1:0]),
    .dec_i      (tick_i && en_q),
    .cnt_o      (pre_cnt),
    .zero_o     (pre_zero)
  );

  cb_temp_lock #(.W(TEMPW)) i_temp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .temp_i (temp_i),
    .hi_i   (t_hi_q),
    .lo_i   (t_lo_q),
    .hot_o  (hot)
  );

  always_comb begin
    if (!en_q)          gate = RS_OFF;
    else if (glob_uv_q) gate = RS_GUV;
    else if (gto_zero)  gate = RS_GTO;
    else if (hot)       gate = RS_HOT;
    else if (!pre_zero) gate = RS_PRE;
    else                gate = RS_ON;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    reason_e code;
    logic    ld_sel;
    assign ld_sel = cfg_we_i && (cfg_ch_i == CHW'(g));

    cb_chan #(.DW(DW), .TW(TW), .VW(VW), .PWMW(PWMW)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .arm_i     (en_q),
      .clr_i     (wr_en),
      .ld_tmr_i  (ld_sel && sel == SEL_CTMR),
      .ld_thr_i  (ld_sel && sel == SEL_CUV),
      .ld_duty_i (ld_sel && sel == SEL_DUTY),
      .data_i    (cfg_data_i),
      .v_i       (cell_v_i[g*VW +: VW]),
      .v_upd_i   (cell_upd_i),
      .ch_en_i   (mask_q[g]),
      .gate_i    (gate),
      .pwm_cnt_i (pwm_cnt_q),
      .bal_o     (bal_o[g]),
      .code_o    (code)
    );
    assign reason_o[3*g +: 3] = code;
  end
endmodule

// File: rtl/cb_bal_chk.sv
module cb_bal_chk #(
  parameter int NCH   = 14,
  parameter int TW    = 16,
  parameter int TEMPW = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic             glob_uv_q,
  input logic             hot,
  input logic             pre_zero,
  input logic             gto_zero,
  input logic [TW-1:0]    gto_cnt,
  input logic             ld_gto,
  input logic             wr_en,
  input logic [TEMPW-1:0] temp_i,
  input logic [TEMPW-1:0] t_hi_q,
  input logic [NCH-1:0]   bal_o
);
  // R1
  off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> bal_o == '0);
  // R2
  budget_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gto_zero |-> bal_o == '0);
  // R4
  pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_zero |-> bal_o == '0);
  // R5
  guv_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_uv_q |-> bal_o == '0);
  // R7
  hot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot |-> bal_o == '0);
  // R7
  hot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_i >= t_hi_q |=> hot);
  // R10
  guv_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_uv_q && !wr_en |=> glob_uv_q);
  // R11
  budget_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_gto |=> gto_cnt <= $past(gto_cnt));
endmodule

bind cell_bal_ctrl cb_bal_chk #(.NCH(NCH), .TW(TW), .TEMPW(TEMPW)) i_cb_bal_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .glob_uv_q (glob_uv_q),
  .hot       (hot),
  .pre_zero  (pre_zero),
  .gto_zero  (gto_zero),
  .gto_cnt   (gto_cnt),
  .ld_gto    (ld_gto),
  .wr_en     (wr_en),
  .temp_i    (temp_i),
  .t_hi_q    (t_hi_q),
  .bal_o     (bal_o)
);

// File: tb/test_cell_bal_ctrl.sv
`timescale 1ns/1ps
module test_cell_bal_ctrl;
  localparam int NCH = 4, DW = 8, TW = 8, VW = 8, TEMPW = 8, PWMW = 2;
  localparam int CHW = 2;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, we = 1'b0, upd = 1'b0;
  logic [3:0] sel = '0;
  logic [CHW-1:0] ch = '0;
  logic [DW-1:0] data = '0;
  logic [NCH*VW-1:0] cell_v = '0;
  logic [TEMPW-1:0] temp = '0;
  logic [NCH-1:0] bal;
  logic [3*NCH-1:0] reason;
  int nvec = 0, nerr = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  cell_bal_ctrl #(.NCH(NCH), .DW(DW), .TW(TW), .VW(VW), .TEMPW(TEMPW), .PWMW(PWMW)) i_cell_bal_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_ch_i(ch), .cfg_data_i(data), .cell_v_i(cell_v), .cell_upd_i(upd),
    .temp_i(temp), .bal_o(bal), .reason_o(reason));

  function automatic logic [3*NCH-1:0] all_code(input logic [2:0] c);
    logic [3*NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[3*i +: 3] = c;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input int c, input int d);
    @(negedge clk);
    we = 1'b1; sel = 4'(s); ch = CHW'(c); data = DW'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic volts(input int a, input int b, input int c, input int d);
    @(negedge clk);
    cell_v = {VW'(d), VW'(c), VW'(b), VW'(a)}; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic set_temp(input int t);
    @(negedge clk); temp = TEMPW'(t);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int cnt [NCH];
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 R12 reset state
    chk("R1 reset bal", 32'(bal), 0);
    chk("R12 reset codes", 32'(reason), 32'(all_code(3'd1)));

    wr(3, 0, 4'hF);
    for (int i = 0; i < NCH; i++) wr(4, i, 100);
    for (int i = 0; i < NCH; i++) wr(7, i, 3);
    wr(8, 0, 200); wr(9, 0, 100); wr(6, 0, 10);
    volts(100, 100, 100, 100);

    wr(0, 0, 1);
    chk("R1 zero budget", 32'(reason), 32'(all_code(3'd3)));
    wr(1, 0, 5);
    chk("R1 running codes", 32'(reason), 0);
    chk("R8 all on", 32'(bal), 32'hF);

    repeat (4) pulse_tick();
    chk("R2 budget 1 left", 32'(reason), 0);
    pulse_tick();
    chk("R2 budget expired", 32'(reason), 32'(all_code(3'd3)));
    chk("R2 switches off", 32'(bal), 0);

    wr(0, 0, 0); wr(2, 0, 3); wr(1, 0, 200); wr(0, 0, 1);
    chk("R4 delay holds", 32'(reason), 32'(all_code(3'd5)));
    set_temp(200);
    chk("R12 hot over delay", 32'(reason), 32'(all_code(3'd4)));
    set_temp(0);
    chk("R4 delay back", 32'(reason), 32'(all_code(3'd5)));
    pulse_tick(); pulse_tick();
    chk("R4 delay 1 left", 32'(reason), 32'(all_code(3'd5)));
    pulse_tick();
    chk("R4 delay done", 32'(reason), 0);

    set_temp(199);
    chk("R7 below high", 32'(reason), 0);
    set_temp(200);
    chk("R7 at high", 32'(reason), 32'(all_code(3'd4)));
    set_temp(150);
    chk("R7 in band", 32'(reason), 32'(all_code(3'd4)));
    set_temp(100);
    chk("R7 at low", 32'(reason), 0);

    wr(4, 1, 2);
    pulse_tick();
    chk("R3 ch1 one left", 32'(reason), 0);
    pulse_tick();
    chk("R3 ch1 expired", 32'(reason), 32'h38);
    chk("R3 ch1 switch", 32'(bal), 32'hD);
    pulse_tick();
    chk("R11 saturated", 32'(reason), 32'h38);
    wr(4, 1, 50);
    chk("R11 reload", 32'(reason), 0);

    wr(5, 2, 50);
    volts(100, 100, 50, 100);
    chk("R6 ch2 low", 32'(reason), 32'h180);
    volts(100, 100, 100, 100);
    chk("R10 ch latch held", 32'(reason), 32'h180);
    wr(0, 0, 1);
    chk("R10 ch latch cleared", 32'(reason), 0);

    volts(10, 100, 100, 100);
    chk("R5 global low", 32'(reason), 32'(all_code(3'd2)));
    volts(100, 100, 100, 100);
    chk("R10 global latch held", 32'(reason), 32'(all_code(3'd2)));
    wr(0, 0, 1);
    chk("R10 global cleared", 32'(reason), 0);

    wr(3, 0, 4'b0101);
    chk("R8 mask codes", 32'(reason), 32'h208);
    chk("R8 mask switches", 32'(bal), 32'h5);
    wr(3, 0, 4'hF);

    // R9 sweep every duty on every channel over full counter periods
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < NCH; i++) wr(7, i, (d + i) % 4);
      for (int i = 0; i < NCH; i++) cnt[i] = 0;
      for (int t = 0; t < 4; t++) begin
        pulse_tick();
        for (int i = 0; i < NCH; i++) cnt[i] += int'(bal[i]);
      end
      for (int i = 0; i < NCH; i++)
        chk($sformatf("R9 duty %0d ch%0d", (d + i) % 4, i), 32'(cnt[i]), 32'((d + i) % 4 + 1));
    end

    wr(0, 0, 0);
    chk("R1 disabled codes", 32'(reason), 32'(all_code(3'd1)));
    chk("R1 disabled switches", 32'(bal), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule